// File: doc/BRIEF.md
# Mode-Selectable Bit-Sliced ALU

This block is a purely combinational arithmetic and logic unit built from a row of identical one-bit slices. The slices are joined by a ripple carry chain. A single mode input chooses between bitwise logic and arithmetic. A two-bit select and a carry-in then pick one of the operations. In arithmetic mode the first operand, not the second, is the one that can be inverted. As a result, all-ones select with carry-in set yields the second operand minus the first.

Each slice takes its own bit of each operand and the carry from the slice below. It returns one result bit and a carry upward. The carry-in port feeds bit 0, and the carry leaving the top slice is the carry-out port. The result and carry-out follow the inputs with no clock and no handshake. The surrounding datapath registers them as it needs.

Top module: `alu_bitslice`

## Requirements
- R1: With `mode_arith`=0, `sel`=00 gives A, 01 gives bitwise NOT A, 10 gives A XOR B, and 11 gives A XNOR B.
- R2: With `mode_arith`=0, `carry_out` is 0 for every operand and select value, including all-ones operands.
- R3: With `mode_arith`=0, `carry_in` has no effect on `result` or `carry_out`.
- R4: When `sel[1]`=0, the B operand has no effect on `result` or `carry_out` in either mode.
- R5: With `mode_arith`=1 and `carry_in`=0, `sel`=00 gives A, 01 gives NOT A, 10 gives A+B, and 11 gives (NOT A)+B. `{carry_out,result}` is the full WIDTH+1 bit sum.
- R6: With `mode_arith`=1 and `carry_in`=1, `sel`=00 gives A+1, 01 gives (NOT A)+1, 10 gives A+B+1, and 11 gives B-A. `{carry_out,result}` is the full WIDTH+1 bit sum.
- R7: With `mode_arith`=1 and `sel`=11, `carry_in`=1, `carry_out` is 1 exactly when B >= A (unsigned), which means no borrow occurred.
- R8: A carry from bit 0 travels through every slice: all-ones A plus 1 gives `result`=0 and `carry_out`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | WIDTH | First operand (the one that may be inverted) |
| b_in | input | WIDTH | Second operand (gated by sel[1]) |
| mode_arith | input | 1 | 0 = bitwise logic, 1 = arithmetic |
| sel | input | 2 | Operation select; sel[0] inverts A, sel[1] enables B |
| carry_in | input | 1 | Carry into bit 0; used only in arithmetic mode |
| result | output | WIDTH | Operation result |
| carry_out | output | 1 | Carry leaving the top slice; 0 in logic mode |

## Verification
Within one evaluation the result word and the carry-out are both produced, and in logic mode the slices still form a local generate term. With `sel`=10 and A=B=all-ones, an ungated chain would raise `carry_out` alongside the XOR word. The bench drives exactly that case, with `carry_in` both 0 and 1, and judges `carry_out`=0 and the result word against a bitwise model. In arithmetic mode, carry and sum meet again on the B-A select. There the bench compares the five-bit pair against a model built from integer subtraction for every operand pair.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef struct packed {
    logic arith;   // 1: carry chain active
    logic use_b;   // 1: second operand enters the slice
    logic inv_a;   // 1: first operand inverted in the slice
  } alu_ctrl_t;

  function automatic alu_ctrl_t make_ctrl(input logic mode, input logic [1:0] sel);
    alu_ctrl_t c;
    c.arith = mode;
    c.use_b = sel[1];
    c.inv_a = sel[0];
    return c;
  endfunction

endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  logic      a_bit,
  input  logic      b_bit,
  input  logic      carry_in,
  input  alu_ctrl_t ctrl,
  output logic      f_bit,
  output logic      carry_out
);

  logic x_op;
  logic y_op;
  logic gen;
  logic prop;
  logic cin_gated;

  always_comb begin
    x_op      = a_bit ^ ctrl.inv_a;
    y_op      = b_bit & ctrl.use_b;
    gen       = x_op & y_op;
    prop      = x_op ^ y_op;
    cin_gated = carry_in & ctrl.arith;
    f_bit     = prop ^ cin_gated;
    carry_out = ctrl.arith & (gen | (prop & carry_in));
  end

endmodule

// File: rtl/alu_ripple.sv
module alu_ripple
  import alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_vec,
  input  logic [WIDTH-1:0] b_vec,
  input  logic             carry_in,
  input  alu_ctrl_t        ctrl,
  output logic [WIDTH-1:0] f_vec,
  output logic             carry_out
);

  logic [WIDTH:0] chain;

  assign chain[0] = carry_in;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    alu_slice u_slice (
      .a_bit    (a_vec[i]),
      .b_bit    (b_vec[i]),
      .carry_in (chain[i]),
      .ctrl     (ctrl),
      .f_bit    (f_vec[i]),
      .carry_out(chain[i+1])
    );
  end

  assign carry_out = chain[WIDTH];

  logic [WIDTH:0] ref_sum;
  logic [WIDTH-1:0] ax;
  logic [WIDTH-1:0] by;

  always_comb begin
    ax      = ctrl.inv_a ? ~a_vec : a_vec;
    by      = ctrl.use_b ? b_vec : '0;
    ref_sum = {1'b0, ax} + {1'b0, by} + {{WIDTH{1'b0}}, carry_in};
    if (!$isunknown({a_vec, b_vec, carry_in, ctrl}) && ctrl.arith)
      AST_ARITH_SUM: assert ({carry_out, f_vec} == ref_sum)
        else $error("ripple sum mismatch"); // R5 R6
  end

endmodule

// File: rtl/alu_bitslice.sv
module alu_bitslice
  import alu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             mode_arith,
  input  logic [1:0]       sel,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  alu_ctrl_t ctrl;

  assign ctrl = make_ctrl(mode_arith, sel);

  alu_ripple #(.WIDTH(WIDTH)) u_ripple (
    .a_vec    (a_in),
    .b_vec    (b_in),
    .carry_in (carry_in),
    .ctrl     (ctrl),
    .f_vec    (result),
    .carry_out(carry_out)
  );

  logic [WIDTH-1:0] a_sel;
  logic [WIDTH:0]   a_only;

  always_comb begin
    a_sel  = a_in ^ (sel[0] ? ALL_ONES : '0);
    a_only = {1'b0, a_sel} + {{WIDTH{1'b0}}, (mode_arith & carry_in)};
    if (!$isunknown({a_in, b_in, mode_arith, sel, carry_in})) begin
      if (!mode_arith) begin
        AST_LOGIC_CARRY_ZERO: assert (carry_out == 1'b0)
          else $error("carry out in logic mode"); // R2
        AST_LOGIC_WORD: assert (result == (a_sel ^ (sel[1] ? b_in : '0)))
          else $error("logic word mismatch"); // R1
      end
      if (!sel[1]) begin
        AST_B_UNUSED: assert ({carry_out, result} == (mode_arith ? a_only : {1'b0, a_sel}))
          else $error("B influenced output"); // R4
      end
    end
  end

endmodule

// File: tb/alu_bitslice_test.sv
module alu_bitslice_test;

  localparam int W    = 4;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a, b, f;
  logic         m, cin, cout;
  logic [1:0]   s;
  int           checks = 0;
  int           errors = 0;
  bit           done   = 0;

  always #10 clk = ~clk;

  alu_bitslice #(.WIDTH(W)) uut (
    .a_in(a), .b_in(b), .mode_arith(m), .sel(s), .carry_in(cin),
    .result(f), .carry_out(cout)
  );

  function automatic logic [W:0] model(input int av, input int bv, input logic mm,
                                       input logic [1:0] ss, input logic cc);
    int na, r;
    na = MAXV - av;
    if (!mm) begin
      case (ss)
        2'b00: r = av;
        2'b01: r = na;
        2'b10: r = av ^ bv;
        default: r = MAXV - (av ^ bv);
      endcase
    end else if (!cc) begin
      case (ss)
        2'b00: r = av;
        2'b01: r = na;
        2'b10: r = av + bv;
        default: r = na + bv;
      endcase
    end else begin
      case (ss)
        2'b00: r = av + 1;
        2'b01: r = na + 1;
        2'b10: r = av + bv + 1;
        default: r = bv - av + MAXV + 1;
      endcase
    end
    return r[W:0];
  endfunction

  task automatic apply(input int av, input int bv, input logic mm,
                       input logic [1:0] ss, input logic cc);
    @(negedge clk);
    a = av[W-1:0]; b = bv[W-1:0]; m = mm; s = ss; cin = cc;
    #5;
  endtask

  task automatic check(input string tag, input logic [W:0] exp_v);
    checks++;
    if ({cout, f} !== exp_v) begin
      errors++;
      $display("FAIL %s: a=%0d b=%0d m=%0b s=%0b c=%0b actual=%0h expected=%0h",
               tag, a, b, m, s, cin, {cout, f}, exp_v);
    end
  endtask

  task automatic t_reset;
    apply(0, 0, 0, 2'b00, 0);
    check("R1 reset idle", '0);
  endtask

  task automatic t_logic_ops;
    for (int ss = 0; ss < 4; ss++) begin
      apply(4'b1100, 4'b1010, 0, ss[1:0], 0);
      check("R1 logic op", model(12, 10, 0, ss[1:0], 0));
    end
  endtask

  task automatic t_logic_carry;
    apply(MAXV, MAXV, 0, 2'b10, 1);
    check("R2 all-ones xor carry zero", '0);
    apply(MAXV, MAXV, 0, 2'b10, 0);
    check("R2 all-ones xor no cin", '0);
  endtask

  task automatic t_cin_ignored;
    for (int ss = 0; ss < 4; ss++) begin
      apply(5, 9, 0, ss[1:0], 1);
      check("R3 cin ignored", model(5, 9, 0, ss[1:0], 0));
    end
  endtask

  task automatic t_b_ignored;
    for (int mm = 0; mm < 2; mm++)
      for (int ss = 0; ss < 2; ss++)
        for (int bv = 0; bv <= MAXV; bv += 5) begin
          apply(6, bv, mm[0], ss[1:0], 1);
          check("R4 B ignored", model(6, 0, mm[0], ss[1:0], 1));
        end
  endtask

  task automatic t_arith_c0;
    for (int ss = 0; ss < 4; ss++) begin
      apply(7, 11, 1, ss[1:0], 0);
      check("R5 arith cin0", model(7, 11, 1, ss[1:0], 0));
    end
  endtask

  task automatic t_arith_c1;
    for (int ss = 0; ss < 4; ss++) begin
      apply(3, 13, 1, ss[1:0], 1);
      check("R6 arith cin1", model(3, 13, 1, ss[1:0], 1));
    end
  endtask

  task automatic t_subtract;
    apply(4, 9, 1, 2'b11, 1);
    check("R7 B>=A no borrow", {1'b1, 4'd5});
    apply(9, 4, 1, 2'b11, 1);
    check("R7 B<A borrow", {1'b0, 4'd11});
    apply(6, 6, 1, 2'b11, 1);
    check("R7 equal", {1'b1, 4'd0});
  endtask

  task automatic t_ripple;
    apply(MAXV, 0, 1, 2'b00, 1);
    check("R8 full ripple A+1", {1'b1, {W{1'b0}}});
    apply(MAXV, 1, 1, 2'b10, 0);
    check("R8 full ripple A+B", {1'b1, {W{1'b0}}});
  endtask

  task automatic t_exhaustive;
    for (int ctl = 0; ctl < 16; ctl++)
      for (int av = 0; av <= MAXV; av++)
        for (int bv = 0; bv <= MAXV; bv++) begin
          apply(av, bv, ctl[3], ctl[2:1], ctl[0]);
          if (ctl[3] && ctl[2:0] == 3'b111)
            check("R7 sweep", model(av, bv, 1, 2'b11, 1));
          else if (ctl[3] && ctl[0])
            check("R6 sweep", model(av, bv, 1, ctl[2:1], 1));
          else if (ctl[3])
            check("R5 sweep", model(av, bv, 1, ctl[2:1], 0));
          else
            check("R1 R3 sweep", model(av, bv, 0, ctl[2:1], 0));
        end
  endtask

  initial begin
    a = '0; b = '0; m = 0; s = 2'b00; cin = 0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset();
    t_logic_ops();
    t_logic_carry();
    t_cin_ignored();
    t_b_ignored();
    t_arith_c0();
    t_arith_c1();
    t_subtract();
    t_ripple();
    t_exhaustive();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int cyc = 0; cyc < 20000; cyc++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule